// File: doc/BRIEF.md
# Fractional UART Baud Tick Generator

The block turns a fast reference clock into the 16x oversampling strobe that a UART transmitter and receiver use to time their bits. The required divisor is the reference frequency over sixteen times the baud rate. It rarely comes out as a whole number, so the divisor is split in two. A 16-bit integer part comes from a high and a low byte. A 6-bit fraction counts in steps of 1/64.

With the fractional feature enabled, a 6-bit phase accumulator adds the fraction once per tick period. Each accumulator carry lengthens the following period by one reference clock. The average period therefore reaches 1/64-clock resolution. With the feature disabled, the fraction has no effect and the block divides by the plain integer.

Any change to a divisor byte, the fraction or the enable restarts the counting cleanly. For example, a 24 MHz clock at 9600 baud needs 156.25. That is programmed as high byte 0x00, low byte 0x9C and fraction 0x10.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `tick_o` is 0.
- R2: A change on any of `div_hi_i`, `div_lo_i`, `div_frac_i` or `frac_en_i` is captured at the next rising edge. That edge clears the period count and the phase accumulator. `tick_o` is then low for D cycles and first goes high in the cycle after the D-th following rising edge, where D = {`div_hi_i`,`div_lo_i`}.
- R3: With `frac_en_i` = 0, every tick period lasts exactly D clocks, whatever `div_frac_i` holds.
- R4: With `frac_en_i` = 1 and fraction F = `div_frac_i`, the first period after a restart lasts D clocks. Period p (p ≥ 1) lasts D + floor(p·F/64) − floor((p−1)·F/64) clocks.
- R5: Any 64 consecutive tick periods span exactly 64·D + F clocks (F taken as 0 when the feature is off).
- R6: D = 0 keeps `tick_o` at 0.
- R7: D = 1 with an effective fraction of 0 makes `tick_o` high on every cycle.
- R8: For D ≥ 2, `tick_o` is a one-cycle pulse and is never high on two cycles in a row.
- R9: The divisor is {`div_hi_i`,`div_lo_i`}, with the high byte as the upper eight bits. With 0x00/0x9C/0x10 and the feature on, 64 periods take 10000 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_hi_i | input | 8 | Upper byte of the integer divisor |
| div_lo_i | input | 8 | Lower byte of the integer divisor |
| div_frac_i | input | 6 | Fractional divisor in 1/64 steps |
| frac_en_i | input | 1 | Enables the fractional divisor |
| tick_o | output | 1 | 16x oversampling strobe |

## Verification
The embedded assertions check local cycle-to-cycle behaviour on every cycle:
- a restart clears the count and silences the tick;
- a zero divisor gives no tick;
- a unit divisor ticks continuously;
- pulses stay one cycle wide for D ≥ 2;
- the count stays inside the current period;
- period stretching only occurs with a nonzero effective fraction.

Other properties span many periods and only the bench scenarios can show them:
- the exact length of every period across the accumulator pattern;
- the 64-period total;
- the latency from a configuration change to the first tick.

The bench's reference model predicts the tick on every clock from the closed-form carry formula.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;
  localparam int BYTE_W     = 8;
  localparam int DEF_DIV_W  = 2 * BYTE_W;
  localparam int DEF_FRAC_W = 6;
endpackage

// File: rtl/fbg_cfg_capture.sv
module fbg_cfg_capture #(
  parameter int DIV_W  = frac_baud_pkg::DEF_DIV_W,
  parameter int FRAC_W = frac_baud_pkg::DEF_FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_in_i,
  input  logic [FRAC_W-1:0] frac_in_i,
  input  logic              en_in_i,
  output logic [DIV_W-1:0]  div_q_o,
  output logic [FRAC_W-1:0] frac_eff_o,
  output logic              restart_o
);
  localparam int CFG_W = DIV_W + FRAC_W + 1;

  logic [CFG_W-1:0] cfg_new, cfg_q;

  assign cfg_new   = {div_in_i, frac_in_i, en_in_i};
  assign restart_o = (cfg_new != cfg_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cfg_q <= '0;
    else if (restart_o) cfg_q <= cfg_new;
  end

  assign div_q_o    = cfg_q[CFG_W-1 -: DIV_W];
  assign frac_eff_o = cfg_q[0] ? cfg_q[FRAC_W:1] : '0;
endmodule

// File: rtl/fbg_phase_accum.sv
module fbg_phase_accum #(
  parameter int FRAC_W = frac_baud_pkg::DEF_FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              period_end_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic [FRAC_W-1:0] phase_o,
  output logic              stretch_o
);
  function automatic logic [FRAC_W:0] phase_step(input logic [FRAC_W-1:0] ph,
                                                 input logic [FRAC_W-1:0] fr);
    return {1'b0, ph} + {1'b0, fr};
  endfunction

  logic [FRAC_W:0] step_w;
  assign step_w = phase_step(phase_o, frac_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o   <= '0;
      stretch_o <= 1'b0;
    end else if (restart_i) begin
      phase_o   <= '0;
      stretch_o <= 1'b0;
    end else if (period_end_i) begin
      phase_o   <= step_w[FRAC_W-1:0];
      stretch_o <= step_w[FRAC_W];
    end
  end

  AST_NO_STRETCH_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frac_i == '0) |=> !stretch_o); // R3
  AST_STRETCH_NEEDS_FRAC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stretch_o |-> (frac_i != '0)); // R5
endmodule

// File: rtl/fbg_period_counter.sv
module fbg_period_counter #(
  parameter int DIV_W = frac_baud_pkg::DEF_DIV_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             stretch_i,
  output logic             period_end_o,
  output logic             tick_o
);
  localparam int CNT_W = DIV_W + 1;

  function automatic logic [CNT_W-1:0] period_len(input logic [DIV_W-1:0] d,
                                                  input logic s);
    return {1'b0, d} + CNT_W'(s);
  endfunction

  logic [CNT_W-1:0] cnt_q, len_w;
  logic             div_zero_w;

  assign len_w        = period_len(div_i, stretch_i);
  assign div_zero_w   = (div_i == '0);
  assign period_end_o = !restart_i && !div_zero_w && (cnt_q == len_w - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (restart_i || div_zero_w) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (period_end_o) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end

  AST_RESTART_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0 && !tick_o)); // R2
  AST_CNT_IN_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !div_zero_w |-> (cnt_q < len_w)); // R4
  AST_ZERO_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_zero_w |=> !tick_o); // R6
  AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i > DIV_W'(1)) |=> !tick_o); // R8
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int DIV_W  = frac_baud_pkg::DEF_DIV_W,
  parameter int FRAC_W = frac_baud_pkg::DEF_FRAC_W
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [frac_baud_pkg::BYTE_W-1:0] div_hi_i,
  input  logic [frac_baud_pkg::BYTE_W-1:0] div_lo_i,
  input  logic [FRAC_W-1:0]               div_frac_i,
  input  logic                            frac_en_i,
  output logic                            tick_o
);
  localparam int HALF_W = DIV_W / 2;

  logic [DIV_W-1:0]  div_in_w, div_q_w;
  logic [FRAC_W-1:0] frac_eff_w, phase_w;
  logic              restart_w, stretch_w, period_end_w;

  assign div_in_w = {div_hi_i[HALF_W-1:0], div_lo_i[HALF_W-1:0]};

  fbg_cfg_capture #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_in_i(div_in_w), .frac_in_i(div_frac_i),
    .en_in_i(frac_en_i), .div_q_o(div_q_w), .frac_eff_o(frac_eff_w),
    .restart_o(restart_w));

  fbg_phase_accum #(.FRAC_W(FRAC_W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart_w),
    .period_end_i(period_end_w), .frac_i(frac_eff_w), .phase_o(phase_w),
    .stretch_o(stretch_w));

  fbg_period_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart_w), .div_i(div_q_w),
    .stretch_i(stretch_w), .period_end_o(period_end_w), .tick_o(tick_o));

  AST_UNIT_DIV_EVERY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q_w == DIV_W'(1) && frac_eff_w == '0 && !restart_w) |=> tick_o); // R7
  AST_RESTART_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_w |=> (phase_w == '0 && !stretch_w)); // R2
endmodule

// File: tb/frac_baud_gen_tb.sv
module frac_baud_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] hi = 8'h00, lo = 8'h00;
  logic [5:0] fr = 6'h00;
  logic       en = 1'b0;
  logic       tick;

  int vectors = 0, miscompares = 0, cycles = 0;
  string cur_req = "R1";

  // reference model state
  int  m_d = 0, m_f = 0, m_pos = 0, m_per = 0;
  int  m_cfg = 0;
  bit  m_exp = 0;

  always #2 clk = ~clk;

  frac_baud_gen u_dut (.clk_i(clk), .rst_ni(rst_n), .div_hi_i(hi), .div_lo_i(lo),
    .div_frac_i(fr), .frac_en_i(en), .tick_o(tick));

  function automatic int carry_of(int p, int f);
    if (p == 0) return 0;
    return (p * f) / 64 - ((p - 1) * f) / 64;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg = 0; m_pos = 0; m_per = 0; m_exp = 0;
    end else begin
      int cfg_now;
      int len;
      cfg_now = ({hi, lo} << 7) | (int'(fr) << 1) | int'(en);
      if (cfg_now != m_cfg) begin
        m_cfg = cfg_now; m_d = {hi, lo}; m_f = en ? int'(fr) : 0;
        m_pos = 0; m_per = 0; m_exp = 0;
      end else if (m_d == 0) begin
        m_exp = 0;
      end else begin
        len = m_d + carry_of(m_per, m_f);
        if (m_pos == len - 1) begin
          m_exp = 1; m_pos = 0; m_per++;
        end else begin
          m_exp = 0; m_pos++;
        end
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    vectors++;
    if (tick !== m_exp) begin
      miscompares++;
      $display("FAIL %s: cycle %0d tick=%b expected %b", cur_req, cycles, tick, m_exp);
    end
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(int d, int f, bit e);
    @(negedge clk);
    hi = 8'(d >> 8); lo = 8'(d); fr = 6'(f); en = e;
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  // clocks spanned by 64 consecutive periods
  task automatic span64(output int total);
    int guard = 0;
    total = 0;
    while (tick !== 1'b1 && guard < 20000) begin @(negedge clk); guard++; end
    for (int k = 0; k < 64; k++) begin
      @(negedge clk); total++;
      while (tick !== 1'b1 && guard < 40000) begin @(negedge clk); total++; guard++; end
    end
  endtask

  initial begin
    int tot, n, cnt;
    // R1: reset state
    run(3);
    check("R1", int'(tick), 0);
    hi = 8'h00; lo = 8'h03;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(tick), 0);
    run(20);

    cur_req = "R3";
    set_cfg(4, 20, 1'b0);
    run(100);
    span64(tot); check("R3", tot, 64 * 4);

    cur_req = "R4";
    set_cfg(5, 20, 1'b1);
    run(400);
    cur_req = "R5";
    span64(tot); check("R5", tot, 64 * 5 + 20);
    set_cfg(2, 63, 1'b1);
    span64(tot); check("R5", tot, 64 * 2 + 63);

    cur_req = "R9";
    set_cfg(16'h009C, 16, 1'b1);
    check("R9", {hi, lo}, 156);
    span64(tot); check("R9", tot, 10000);

    cur_req = "R6";
    set_cfg(0, 5, 1'b1);
    cnt = 0;
    for (int i = 0; i < 50; i++) begin @(negedge clk); if (tick) cnt++; end
    check("R6", cnt, 0);

    cur_req = "R7";
    set_cfg(1, 0, 1'b1);
    run(1);
    cnt = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (tick) cnt++; end
    check("R7", cnt, 30);

    cur_req = "R8";
    set_cfg(2, 0, 1'b0);
    run(4);
    cnt = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (tick) begin @(negedge clk); if (tick) cnt++; end
    end
    check("R8", cnt, 0);

    cur_req = "R2";
    set_cfg(9, 7, 1'b1);
    run(13);
    set_cfg(7, 7, 1'b1);
    n = 0;
    do begin @(negedge clk); n++; end while (tick !== 1'b1 && n < 100);
    check("R2", n, 8);
    run(5);
    fr = 6'd30; // fraction change alone also restarts
    n = 0;
    do begin @(negedge clk); n++; end while (tick !== 1'b1 && n < 100);
    check("R2", n, 8);
    run(200);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule